// File: doc/BRIEF.md
# Stereo Audio Digital Path Router

This block steers stereo audio samples between a capture front end, an external filter and gain stage, and the serial output and volume path. The capture side offers two sources: one derived from analog inputs and one derived from a digital microphone. A source-type bit chooses which of the two sources is used. It also chooses which of the two per-channel enable pairs applies. The enable pair gates the channels and maps them into the output slots. With both enables off, both slots carry silence. With one enable on, that channel is copied into both slots for mono capture. With both on, the stream is normal stereo.

A feed-select bit chooses what the filter stage receives: the mapped capture stream or the serial input stream. The filter and gain stage lives outside this block. It is reached through a registered send port and a return port, and each port has its own valid. Samples coming back can be folded to mono as (L+R)/2 in both slots. A final output-select bit chooses what drives the serial output and volume path: the mapped capture data or the processed return data.

All samples are 24-bit two's complement. Every stream moves on single-cycle valid strobes. Control bits are static inputs. They are sampled only when a sample is accepted, so a control change affects the next sample and never a sample already held.

Top module: `audio_path_router`

## Requirements
- R1: While `rst` is high at a clock edge, all sample outputs become zero and `out_valid_o` and `flt_in_valid_o` become 0.
- R2: If the selected enable pair is {left=0, right=0}, a capture sample yields 0 in both the left and the right slot.
- R3: If the selected enable pair is {left=0, right=1}, the right capture sample is placed in both slots.
- R4: If the selected enable pair is {left=1, right=0}, the left capture sample is placed in both slots.
- R5: If the selected enable pair is {left=1, right=1}, the left sample goes to the left slot and the right sample goes to the right slot.
- R6: `src_dmic_i`=1 takes the samples from `dmic_l_i`/`dmic_r_i` and the mapping from `en_dmic_l_i`/`en_dmic_r_i`. `src_dmic_i`=0 takes the samples from `ana_l_i`/`ana_r_i` and the mapping from `en_ana_l_i`/`en_ana_r_i`.
- R7: With `feed_ser_i`=0, the filter send port carries the mapped capture sample one cycle after `cap_valid_i`. With `feed_ser_i`=1, it carries the serial sample one cycle after `ser_valid_i`. `flt_in_valid_o` pulses in that same cycle.
- R8: With `out_proc_i`=1 and `mono_i`=1, both output slots carry floor((L+R)/2) of the returned filter pair. The sum is taken at 25 bits, so the result never overflows.
- R9: With `out_proc_i`=1 and `mono_i`=0, the returned left and right samples pass to the output unchanged.
- R10: `out_proc_i`=0 drives the output from the mapped capture data. `out_proc_i`=1 drives it from the processed return data.
- R11: `out_valid_o` is high exactly one cycle after the valid of the selected output source. The output samples change only then and otherwise hold, even when control bits change.
- R12: A valid strobe on a stream that is not selected has no effect on the output: no pulse on `out_valid_o` and no change in the samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ana_l_i | input | 24 | Analog-derived capture, left |
| ana_r_i | input | 24 | Analog-derived capture, right |
| dmic_l_i | input | 24 | Digital-microphone capture, left |
| dmic_r_i | input | 24 | Digital-microphone capture, right |
| cap_valid_i | input | 1 | Capture sample strobe (both sources) |
| ser_l_i | input | 24 | Serial input path, left |
| ser_r_i | input | 24 | Serial input path, right |
| ser_valid_i | input | 1 | Serial input sample strobe |
| en_ana_l_i | input | 1 | Analog left enable |
| en_ana_r_i | input | 1 | Analog right enable |
| en_dmic_l_i | input | 1 | Digital-microphone left enable |
| en_dmic_r_i | input | 1 | Digital-microphone right enable |
| src_dmic_i | input | 1 | 1 selects digital-microphone source and enables |
| feed_ser_i | input | 1 | 1 feeds filter from serial input |
| mono_i | input | 1 | 1 folds processed data to (L+R)/2 |
| out_proc_i | input | 1 | 1 drives output from processed data |
| flt_in_l_o | output | 24 | Filter send, left |
| flt_in_r_o | output | 24 | Filter send, right |
| flt_in_valid_o | output | 1 | Filter send strobe |
| flt_out_l_i | input | 24 | Filter return, left |
| flt_out_r_i | input | 24 | Filter return, right |
| flt_out_valid_i | input | 1 | Filter return strobe |
| out_l_o | output | 24 | Serial output / volume path, left |
| out_r_o | output | 24 | Serial output / volume path, right |
| out_valid_o | output | 1 | Output sample strobe |

## Verification
Several properties are checked on every cycle. The reset clearing, the one-cycle latency of both valids, and the output holding between samples are among them. Others are the silence for a disabled pair, the copy of one channel into both slots, equal slots under the mono fold, and the absence of any effect from an unselected strobe. The values themselves can only be shown by the bench's scenarios. These are the exact floor of (L+R)/2 at the extremes of the range, the choice between analog and microphone data, and a control change taking effect only on the next accepted sample.

// File: rtl/apr_pkg.sv
package apr_pkg;
  parameter int unsigned SAMPLE_W = 24;
  localparam int unsigned NUM_SRC = 2;
  localparam int unsigned SRC_ANA = 0;
  localparam int unsigned SRC_DMIC = 1;

  typedef enum logic [1:0] {
    MAP_SILENT = 2'b00,
    MAP_DUP_R  = 2'b01,
    MAP_DUP_L  = 2'b10,
    MAP_STEREO = 2'b11
  } map_mode_e;
endpackage

// File: rtl/apr_chan_map.sv
module apr_chan_map #(
  parameter int unsigned W = 24
) (
  input  logic         en_l,
  input  logic         en_r,
  input  logic [W-1:0] in_l,
  input  logic [W-1:0] in_r,
  output logic [W-1:0] map_l,
  output logic [W-1:0] map_r
);
  import apr_pkg::*;

  map_mode_e mode;
  assign mode = map_mode_e'({en_l, en_r});

  always_comb begin
    unique case (mode)
      MAP_SILENT: begin map_l = '0;   map_r = '0;   end
      MAP_DUP_R:  begin map_l = in_r; map_r = in_r; end
      MAP_DUP_L:  begin map_l = in_l; map_r = in_l; end
      default:    begin map_l = in_l; map_r = in_r; end
    endcase
  end
endmodule

// File: rtl/apr_mono_fold.sv
module apr_mono_fold #(
  parameter int unsigned W = 24
) (
  input  logic         fold,
  input  logic [W-1:0] in_l,
  input  logic [W-1:0] in_r,
  output logic [W-1:0] out_l,
  output logic [W-1:0] out_r
);
  localparam int unsigned SUM_W = W + 1;

  logic [SUM_W-1:0] sum;
  logic [W-1:0]     half;

  // sign-extend both operands one bit, add, then drop the LSB (arithmetic >>1)
  assign sum  = {in_l[W-1], in_l} + {in_r[W-1], in_r};
  assign half = sum[SUM_W-1:1];

  assign out_l = fold ? half : in_l;
  assign out_r = fold ? half : in_r;
endmodule

// File: rtl/apr_sample_reg.sv
module apr_sample_reg #(
  parameter int unsigned W = 24
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] d_l,
  input  logic [W-1:0] d_r,
  output logic [W-1:0] q_l,
  output logic [W-1:0] q_r,
  output logic         q_valid
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q_l     <= '0;
      q_r     <= '0;
      q_valid <= 1'b0;
    end else begin
      q_valid <= load;
      if (load) begin
        q_l <= d_l;
        q_r <= d_r;
      end
    end
  end
endmodule

// File: rtl/audio_path_router.sv
module audio_path_router #(
  parameter int unsigned W = apr_pkg::SAMPLE_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] ana_l_i,
  input  logic [W-1:0] ana_r_i,
  input  logic [W-1:0] dmic_l_i,
  input  logic [W-1:0] dmic_r_i,
  input  logic         cap_valid_i,
  input  logic [W-1:0] ser_l_i,
  input  logic [W-1:0] ser_r_i,
  input  logic         ser_valid_i,
  input  logic         en_ana_l_i,
  input  logic         en_ana_r_i,
  input  logic         en_dmic_l_i,
  input  logic         en_dmic_r_i,
  input  logic         src_dmic_i,
  input  logic         feed_ser_i,
  input  logic         mono_i,
  input  logic         out_proc_i,
  output logic [W-1:0] flt_in_l_o,
  output logic [W-1:0] flt_in_r_o,
  output logic         flt_in_valid_o,
  input  logic [W-1:0] flt_out_l_i,
  input  logic [W-1:0] flt_out_r_i,
  input  logic         flt_out_valid_i,
  output logic [W-1:0] out_l_o,
  output logic [W-1:0] out_r_o,
  output logic         out_valid_o
);
  import apr_pkg::*;

  // per-source inputs gathered into arrays, indexed by SRC_ANA / SRC_DMIC
  logic [W-1:0] src_l   [NUM_SRC];
  logic [W-1:0] src_r   [NUM_SRC];
  logic         src_enl [NUM_SRC];
  logic         src_enr [NUM_SRC];
  logic [W-1:0] map_l   [NUM_SRC];
  logic [W-1:0] map_r   [NUM_SRC];

  assign src_l[SRC_ANA]    = ana_l_i;
  assign src_r[SRC_ANA]    = ana_r_i;
  assign src_enl[SRC_ANA]  = en_ana_l_i;
  assign src_enr[SRC_ANA]  = en_ana_r_i;
  assign src_l[SRC_DMIC]   = dmic_l_i;
  assign src_r[SRC_DMIC]   = dmic_r_i;
  assign src_enl[SRC_DMIC] = en_dmic_l_i;
  assign src_enr[SRC_DMIC] = en_dmic_r_i;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_map
    apr_chan_map #(.W(W)) u_map (
      .en_l  (src_enl[g]),
      .en_r  (src_enr[g]),
      .in_l  (src_l[g]),
      .in_r  (src_r[g]),
      .map_l (map_l[g]),
      .map_r (map_r[g])
    );
  end

  logic [W-1:0] cap_l, cap_r;
  assign cap_l = src_dmic_i ? map_l[SRC_DMIC] : map_l[SRC_ANA];
  assign cap_r = src_dmic_i ? map_r[SRC_DMIC] : map_r[SRC_ANA];

  // filter send stage
  logic [W-1:0] feed_l, feed_r;
  logic         feed_valid;
  assign feed_l     = feed_ser_i ? ser_l_i     : cap_l;
  assign feed_r     = feed_ser_i ? ser_r_i     : cap_r;
  assign feed_valid = feed_ser_i ? ser_valid_i : cap_valid_i;

  apr_sample_reg #(.W(W)) u_feed_reg (
    .clk     (clk),
    .rst     (rst),
    .load    (feed_valid),
    .d_l     (feed_l),
    .d_r     (feed_r),
    .q_l     (flt_in_l_o),
    .q_r     (flt_in_r_o),
    .q_valid (flt_in_valid_o)
  );

  // processed return with optional mono fold
  logic [W-1:0] proc_l, proc_r;
  apr_mono_fold #(.W(W)) u_fold (
    .fold  (mono_i),
    .in_l  (flt_out_l_i),
    .in_r  (flt_out_r_i),
    .out_l (proc_l),
    .out_r (proc_r)
  );

  // output select and register
  logic [W-1:0] sel_l, sel_r;
  logic         sel_valid;
  assign sel_l     = out_proc_i ? proc_l          : cap_l;
  assign sel_r     = out_proc_i ? proc_r          : cap_r;
  assign sel_valid = out_proc_i ? flt_out_valid_i : cap_valid_i;

  apr_sample_reg #(.W(W)) u_out_reg (
    .clk     (clk),
    .rst     (rst),
    .load    (sel_valid),
    .d_l     (sel_l),
    .d_r     (sel_r),
    .q_l     (out_l_o),
    .q_r     (out_r_o),
    .q_valid (out_valid_o)
  );
endmodule

// File: rtl/apr_checker.sv
module apr_checker #(
  parameter int unsigned W = 24
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] ana_l_i,
  input logic [W-1:0] ana_r_i,
  input logic [W-1:0] dmic_l_i,
  input logic [W-1:0] dmic_r_i,
  input logic         cap_valid_i,
  input logic         ser_valid_i,
  input logic         en_ana_l_i,
  input logic         en_ana_r_i,
  input logic         en_dmic_l_i,
  input logic         en_dmic_r_i,
  input logic         src_dmic_i,
  input logic         feed_ser_i,
  input logic         mono_i,
  input logic         out_proc_i,
  input logic [W-1:0] flt_in_l_o,
  input logic [W-1:0] flt_in_r_o,
  input logic         flt_in_valid_o,
  input logic         flt_out_valid_i,
  input logic [W-1:0] out_l_o,
  input logic [W-1:0] out_r_o,
  input logic         out_valid_o
);
  logic rst_q = 1'b0;
  logic live  = 1'b0;
  always_ff @(posedge clk) begin
    rst_q <= rst;
    live  <= !rst;
  end

  logic sel_en_l, sel_en_r, cap_take;
  logic [W-1:0] sel_in_l, sel_in_r;
  assign sel_en_l = src_dmic_i ? en_dmic_l_i : en_ana_l_i;
  assign sel_en_r = src_dmic_i ? en_dmic_r_i : en_ana_r_i;
  assign sel_in_l = src_dmic_i ? dmic_l_i : ana_l_i;
  assign sel_in_r = src_dmic_i ? dmic_r_i : ana_r_i;
  assign cap_take = cap_valid_i && !out_proc_i;

  AST_RESET_CLEAR: assert property (@(posedge clk) rst_q |-> (!out_valid_o && !flt_in_valid_o && out_l_o == '0 && out_r_o == '0 && flt_in_l_o == '0 && flt_in_r_o == '0)); // R1
  AST_ZERO_WHEN_OFF: assert property (@(posedge clk) disable iff (rst) live && $past(cap_take && !sel_en_l && !sel_en_r) |-> (out_l_o == '0 && out_r_o == '0)); // R2
  AST_DUP_RIGHT: assert property (@(posedge clk) disable iff (rst) live && $past(cap_take && !sel_en_l && sel_en_r) |-> (out_l_o == $past(sel_in_r) && out_r_o == $past(sel_in_r))); // R3
  AST_DUP_LEFT: assert property (@(posedge clk) disable iff (rst) live && $past(cap_take && sel_en_l && !sel_en_r) |-> (out_l_o == $past(sel_in_l) && out_r_o == $past(sel_in_l))); // R4
  AST_FEED_LATENCY: assert property (@(posedge clk) disable iff (rst) live |-> (flt_in_valid_o == $past(feed_ser_i ? ser_valid_i : cap_valid_i))); // R7
  AST_FOLD_EQUAL: assert property (@(posedge clk) disable iff (rst) live && $past(out_proc_i && mono_i && flt_out_valid_i) |-> (out_l_o == out_r_o)); // R8
  AST_OUT_LATENCY: assert property (@(posedge clk) disable iff (rst) live |-> (out_valid_o == $past(out_proc_i ? flt_out_valid_i : cap_valid_i))); // R11
  AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (rst) live && !out_valid_o |-> ($stable(out_l_o) && $stable(out_r_o))); // R11
  AST_IGNORE_UNSELECTED: assert property (@(posedge clk) disable iff (rst) live && $past(!out_proc_i && !cap_valid_i && flt_out_valid_i) |-> (!out_valid_o && $stable(out_l_o))); // R12
endmodule

bind audio_path_router apr_checker #(.W(W)) u_apr_checker (
  .clk             (clk),
  .rst             (rst),
  .ana_l_i         (ana_l_i),
  .ana_r_i         (ana_r_i),
  .dmic_l_i        (dmic_l_i),
  .dmic_r_i        (dmic_r_i),
  .cap_valid_i     (cap_valid_i),
  .ser_valid_i     (ser_valid_i),
  .en_ana_l_i      (en_ana_l_i),
  .en_ana_r_i      (en_ana_r_i),
  .en_dmic_l_i     (en_dmic_l_i),
  .en_dmic_r_i     (en_dmic_r_i),
  .src_dmic_i      (src_dmic_i),
  .feed_ser_i      (feed_ser_i),
  .mono_i          (mono_i),
  .out_proc_i      (out_proc_i),
  .flt_in_l_o      (flt_in_l_o),
  .flt_in_r_o      (flt_in_r_o),
  .flt_in_valid_o  (flt_in_valid_o),
  .flt_out_valid_i (flt_out_valid_i),
  .out_l_o         (out_l_o),
  .out_r_o         (out_r_o),
  .out_valid_o     (out_valid_o)
);

// File: tb/tb_audio_path_router.sv
`timescale 1ns/1ps
module tb_audio_path_router;
  localparam int W = 24;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [W-1:0] ana_l = '0, ana_r = '0, dmic_l = '0, dmic_r = '0;
  logic [W-1:0] ser_l = '0, ser_r = '0, fo_l = '0, fo_r = '0;
  logic cap_v = 0, ser_v = 0, fo_v = 0;
  logic ea_l = 0, ea_r = 0, ed_l = 0, ed_r = 0;
  logic src_d = 0, feed_s = 0, mono = 0, oproc = 0;
  logic [W-1:0] fi_l, fi_r, o_l, o_r;
  logic fi_v, o_v;

  audio_path_router #(.W(W)) dut (
    .clk(clk), .rst(rst),
    .ana_l_i(ana_l), .ana_r_i(ana_r), .dmic_l_i(dmic_l), .dmic_r_i(dmic_r),
    .cap_valid_i(cap_v), .ser_l_i(ser_l), .ser_r_i(ser_r), .ser_valid_i(ser_v),
    .en_ana_l_i(ea_l), .en_ana_r_i(ea_r), .en_dmic_l_i(ed_l), .en_dmic_r_i(ed_r),
    .src_dmic_i(src_d), .feed_ser_i(feed_s), .mono_i(mono), .out_proc_i(oproc),
    .flt_in_l_o(fi_l), .flt_in_r_o(fi_r), .flt_in_valid_o(fi_v),
    .flt_out_l_i(fo_l), .flt_out_r_i(fo_r), .flt_out_valid_i(fo_v),
    .out_l_o(o_l), .out_r_o(o_r), .out_valid_o(o_v)
  );

  int n_tests = 0;
  int n_fail  = 0;
  logic [W-1:0] e_ol = '0, e_or = '0, e_fl = '0, e_fr = '0;
  logic e_ov = 0, e_fv = 0;

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // mapping per R2..R5: returns {left_slot, right_slot}
  function automatic logic [2*W-1:0] map_pair(logic el, logic er, logic [W-1:0] l, logic [W-1:0] r);
    if (!el && !er) return '0;
    if (!el && er)  return {r, r};
    if (el && !er)  return {l, l};
    return {l, r};
  endfunction

  // floor((L+R)/2) on signed values per R8
  function automatic logic [W-1:0] avg(logic [W-1:0] l, logic [W-1:0] r);
    int s;
    s = int'($signed(l)) + int'($signed(r));
    s = s >>> 1;
    return s[W-1:0];
  endfunction

  function automatic logic [2*W-1:0] cap_pair();
    return src_d ? map_pair(ed_l, ed_r, dmic_l, dmic_r) : map_pair(ea_l, ea_r, ana_l, ana_r);
  endfunction

  // update expected state from inputs currently driven (called after driving at negedge)
  task automatic model();
    logic [2*W-1:0] c;
    c = cap_pair();
    e_fv = feed_s ? ser_v : cap_v;
    if (e_fv) begin
      e_fl = feed_s ? ser_l : c[2*W-1:W];
      e_fr = feed_s ? ser_r : c[W-1:0];
    end
    e_ov = oproc ? fo_v : cap_v;
    if (e_ov) begin
      if (oproc) begin
        e_ol = mono ? avg(fo_l, fo_r) : fo_l;
        e_or = mono ? avg(fo_l, fo_r) : fo_r;
      end else begin
        e_ol = c[2*W-1:W];
        e_or = c[W-1:0];
      end
    end
  endtask

  function automatic string out_req();
    if (oproc) return mono ? "R8" : "R9";
    if (src_d) return "R6";
    case ({ea_l, ea_r})
      2'b00: return "R2";
      2'b01: return "R3";
      2'b10: return "R4";
      default: return "R5";
    endcase
  endfunction

  // one cycle: inputs already set at a negedge; model, wait one edge, compare at next negedge
  task automatic step_check();
    string rq;
    rq = out_req();
    model();
    @(negedge clk);
    chk(rq, o_l, e_ol);
    chk(rq, o_r, e_or);
    chk("R11", {23'd0, o_v}, {23'd0, e_ov});
    chk("R7", fi_l, e_fl);
    chk("R7", fi_r, e_fr);
    chk("R7", {23'd0, fi_v}, {23'd0, e_fv});
  endtask

  task automatic idle();
    cap_v = 0; ser_v = 0; fo_v = 0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    int unsigned seed;
    seed = 32'h5eed_a0d1;
    void'($urandom(seed));
    ana_l = 24'h123456; fo_v = 1; cap_v = 1; ser_v = 1;
    repeat (3) @(negedge clk);
    // R1: reset state despite active strobes
    chk("R1", o_l, '0); chk("R1", o_r, '0);
    chk("R1", {23'd0, o_v}, '0); chk("R1", {23'd0, fi_v}, '0);
    idle();
    rst = 0;
    @(negedge clk);

    // R6 directed: analog vs microphone with differing enable pairs
    ana_l = 24'h111111; ana_r = 24'h222222; dmic_l = 24'h333333; dmic_r = 24'h444444;
    ea_l = 1; ea_r = 1; ed_l = 0; ed_r = 1; src_d = 1; cap_v = 1;
    step_check();
    chk("R6", o_l, 24'h444444);
    src_d = 0;
    step_check();
    chk("R6", o_r, 24'h222222);
    idle();

    // R11 directed: control change without a sample leaves the output held
    ea_l = 0; ea_r = 0; src_d = 0;
    step_check();
    chk("R11", o_l, 24'h111111);
    // next accepted sample uses the new control
    cap_v = 1; step_check(); idle();
    chk("R2", o_l, '0);

    // R12 directed: return strobe ignored while output uses capture
    oproc = 0; fo_l = 24'h0ABCDE; fo_v = 1;
    step_check();
    chk("R12", {23'd0, o_v}, '0);
    chk("R12", o_l, '0);
    idle();

    // R8 corners and R10 switch to processed data
    oproc = 1; mono = 1; fo_v = 1;
    fo_l = 24'h7FFFFF; fo_r = 24'h7FFFFF; step_check(); chk("R8", o_l, 24'h7FFFFF);
    fo_l = 24'h800000; fo_r = 24'h800000; step_check(); chk("R8", o_r, 24'h800000);
    fo_l = 24'hFFFFFF; fo_r = 24'h000000; step_check(); chk("R8", o_l, 24'hFFFFFF);
    fo_l = 24'h7FFFFF; fo_r = 24'h800000; step_check(); chk("R8", o_l, 24'hFFFFFF);
    mono = 0; fo_l = 24'h010203; fo_r = 24'h040506; step_check();
    chk("R10", o_r, 24'h040506);
    idle();

    // constrained random traffic
    for (int i = 0; i < 4000; i++) begin
      ana_l = W'($urandom); ana_r = W'($urandom);
      dmic_l = W'($urandom); dmic_r = W'($urandom);
      ser_l = W'($urandom); ser_r = W'($urandom);
      fo_l = W'($urandom); fo_r = W'($urandom);
      if (($urandom % 8) == 0) fo_l = {1'b1, {(W-1){1'b0}}};
      cap_v = ($urandom % 3) == 0; ser_v = ($urandom % 3) == 0; fo_v = ($urandom % 3) == 0;
      {ea_l, ea_r, ed_l, ed_r} = 4'($urandom);
      src_d = 1'($urandom); feed_s = 1'($urandom);
      mono = 1'($urandom); oproc = 1'($urandom);
      step_check();
    end
    idle();

    // R1 mid-run reset
    rst = 1; cap_v = 1; @(negedge clk);
    chk("R1", o_l, '0); chk("R1", {23'd0, o_v}, '0); chk("R1", fi_r, '0);
    rst = 0; idle();

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule